// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block connects a simple internal request port to an external parallel bus. The bus has a 24-bit address, a 16-bit data path and active-low chip-select, read and write strobes. Each access goes through a small state machine. The machine uses one setup clock and one strobe clock, followed by a programmable run of wait states. The run length is chosen per chip-select region. The request port reports not-ready for the whole access, which stalls the processor while the wait states run.

Each region has an enable, a base address and a power-of-two size. An access falls in a region when the address bits above the size match the base. When regions overlap, the lowest-numbered enabled region wins. The wait count of a region is built from two fields: a fine field of 4 bits and a coarse field of 2 bits worth 8 states each. The total is capped at 31. A global ISA-compatible mode adds one wait state to reads only, and launches the read strobe from the falling clock edge, half a clock late. The data bus is split into an output, an input and an output enable.

State machine: `ST_IDLE` (ready, no strobes) goes to `ST_SETUP` on an accepted request. `ST_SETUP` (address and CS driven) always goes to `ST_STROBE`. `ST_STROBE` goes to `ST_IDLE` when the loaded wait count is zero, and otherwise goes to `ST_WAIT`. `ST_WAIT` counts down and returns to `ST_IDLE` on the edge that ends the last wait state. That edge also captures the read data and releases the strobes. The response is presented during the following `ST_IDLE` clock.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, all `bus_cs_n` bits, `bus_rd_n` and `bus_wr_n` are 1, and `bus_oe` and `rsp_valid` are 0.
- R2: An access drives low exactly the `bus_cs_n` bit of the lowest-indexed enabled region whose base matches the address above its size (`cfg_size` field = log2 of the region size in bytes). The bit is low from the setup clock through the last strobe or wait clock.
- R3: Without the ISA read extra, the wait count n is fine + 8 × coarse. `req_ready` is low for n + 2 clocks after the accepting edge, and `rsp_valid` is high for one clock on the (n + 2)-th edge after it.
- R4: In ISA mode, a read gets one extra wait state. Its RD strobe is high in the first half of the strobe clock and low from the falling edge on. Without ISA mode, RD goes low on the rising edge that starts the strobe clock.
- R5: ISA mode leaves write timing unchanged: the write has the same wait count, and WR is low from the strobe clock through the last wait clock.
- R6: The total wait count, including the ISA read extra, never exceeds 31.
- R7: An address outside every enabled region asserts no CS and uses zero wait states, even for ISA reads. A read returns 16'hFFFF.
- R8: `bus_oe` is 1 only during write accesses, from the setup clock through the last wait clock, and `bus_dout` carries the write data then.
- R9: `rsp_rdata` equals `bus_din` as sampled on the edge that ends the access.
- R10: In the response clock the block is already ready again with every CS deasserted. A request presented then is accepted, leaving exactly one idle clock between accesses.
- R11: `bus_addr` holds the accepted address for the whole access and after it, even when the request inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (low = processor stalled) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Request address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| cfg_isa | input | 1 | ISA-compatible read timing |
| cfg_en | input | 4 | Per-region enable |
| cfg_base | input | 96 | Per-region base address, 24 bits each |
| cfg_size | input | 20 | Per-region log2 size, 5 bits each |
| cfg_wait_lo | input | 16 | Per-region fine wait field, 4 bits each |
| cfg_wait_hi | input | 8 | Per-region coarse wait field (×8), 2 bits each |
| bus_addr | output | 24 | External address |
| bus_dout | output | 16 | External write data |
| bus_oe | output | 1 | Data output enable |
| bus_din | input | 16 | External read data |
| bus_cs_n | output | 4 | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |

## Verification
Two functions share one clock: the response of the finished access and the acceptance of the next request. Both happen in the single idle clock that follows the ending edge. The bench provokes this by issuing a second request in the middle of the response clock. It then judges that `rsp_valid` and `req_ready` are high together with every CS high, and that the next clock is already the setup clock of the new access with its CS low. A second collision is covered by a near-exhaustive sweep of both wait fields with ISA mode and direction: the ISA read extra meets saturation at 31. The expected timing is computed in the bench from the fields.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_WAIT
    } xbus_state_e;
endpackage

// File: rtl/xbus_wait_calc.sv
// Turns the two per-region wait fields into a saturated wait-state count.
module xbus_wait_calc #(
    parameter int LO_W     = 4,
    parameter int HI_W     = 2,
    parameter int HI_SCALE = 8,
    parameter int MAX_WAIT = 31,
    parameter int CNT_W    = $clog2(MAX_WAIT + 1)
) (
    input  logic [LO_W-1:0]  lo,
    input  logic [HI_W-1:0]  hi,
    input  logic             extra,
    output logic [CNT_W-1:0] total
);
    localparam int SUM_W = CNT_W + HI_W + 2;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(lo) + SUM_W'(hi) * SUM_W'(HI_SCALE) + SUM_W'(extra);
        if (sum > SUM_W'(MAX_WAIT)) begin
            total = CNT_W'(MAX_WAIT);
        end else begin
            total = sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/xbus_region_dec.sv
// Matches an address against every region; the lowest enabled index wins.
module xbus_region_dec #(
    parameter int NCS    = 4,
    parameter int ADDR_W = 24,
    parameter int SZ_W   = $clog2(ADDR_W + 1),
    parameter int LO_W   = 4,
    parameter int HI_W   = 2
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NCS-1:0]        en,
    input  logic [NCS*ADDR_W-1:0] base,
    input  logic [NCS*SZ_W-1:0]   size,
    input  logic [NCS*LO_W-1:0]   lo_flat,
    input  logic [NCS*HI_W-1:0]   hi_flat,
    output logic                  hit,
    output logic [NCS-1:0]        sel,
    output logic [LO_W-1:0]       lo,
    output logic [HI_W-1:0]       hi
);
    logic [NCS-1:0] match;

    for (genvar g = 0; g < NCS; g++) begin : g_region
        logic [ADDR_W-1:0] diff;
        logic [SZ_W-1:0]   sz;
        assign diff     = addr ^ base[g*ADDR_W +: ADDR_W];
        assign sz       = size[g*SZ_W +: SZ_W];
        assign match[g] = en[g] && ((32'(sz) >= ADDR_W) || ((diff >> sz) == '0));
    end

    always_comb begin
        hit = 1'b0;
        sel = '0;
        lo  = '0;
        hi  = '0;
        for (int i = NCS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit    = 1'b1;
                sel    = '0;
                sel[i] = 1'b1;
                lo     = lo_flat[i*LO_W +: LO_W];
                hi     = hi_flat[i*HI_W +: HI_W];
            end
        end
    end
endmodule

// File: rtl/xbus_late_rd.sv
// Falling-edge flop that launches the delayed read strobe.
module xbus_late_rd (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic late_q
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            late_q <= 1'b0;
        end else begin
            late_q <= arm;
        end
    end
endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
    import xbus_pkg::*;
#(
    parameter int NCS      = 4,
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 16,
    parameter int LO_W     = 4,
    parameter int HI_W     = 2,
    parameter int HI_SCALE = 8,
    parameter int MAX_WAIT = 31,
    parameter int SZ_W     = $clog2(ADDR_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    input  logic                  cfg_isa,
    input  logic [NCS-1:0]        cfg_en,
    input  logic [NCS*ADDR_W-1:0] cfg_base,
    input  logic [NCS*SZ_W-1:0]   cfg_size,
    input  logic [NCS*LO_W-1:0]   cfg_wait_lo,
    input  logic [NCS*HI_W-1:0]   cfg_wait_hi,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W-1:0]     bus_dout,
    output logic                  bus_oe,
    input  logic [DATA_W-1:0]     bus_din,
    output logic [NCS-1:0]        bus_cs_n,
    output logic                  bus_rd_n,
    output logic                  bus_wr_n
);
    localparam int CNT_W = $clog2(MAX_WAIT + 1);

    xbus_state_e      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              write_q, isa_q, hit_q, rsp_q;
    logic [NCS-1:0]    sel_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              dec_hit;
    logic [NCS-1:0]    dec_sel;
    logic [LO_W-1:0]   dec_lo;
    logic [HI_W-1:0]   dec_hi;
    logic [CNT_W-1:0]  wait_total;
    logic              accept, end_acc, strobe_ph, active, late_q;

    xbus_region_dec #(
        .NCS(NCS), .ADDR_W(ADDR_W), .SZ_W(SZ_W), .LO_W(LO_W), .HI_W(HI_W)
    ) dec_i (
        .addr(req_addr), .en(cfg_en), .base(cfg_base), .size(cfg_size),
        .lo_flat(cfg_wait_lo), .hi_flat(cfg_wait_hi),
        .hit(dec_hit), .sel(dec_sel), .lo(dec_lo), .hi(dec_hi)
    );

    // Unmapped accesses get fields of zero and no ISA extra.
    xbus_wait_calc #(
        .LO_W(LO_W), .HI_W(HI_W), .HI_SCALE(HI_SCALE),
        .MAX_WAIT(MAX_WAIT), .CNT_W(CNT_W)
    ) calc_i (
        .lo(dec_lo), .hi(dec_hi),
        .extra(cfg_isa && !req_write && dec_hit),
        .total(wait_total)
    );

    xbus_late_rd late_i (
        .clk(clk), .rst_n(rst_n),
        .arm(strobe_ph && isa_q && !write_q),
        .late_q(late_q)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        end_acc = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                    end_acc = 1'b1;
                end else begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (cnt_q == CNT_W'(1)) begin
                    state_d = ST_IDLE;
                    end_acc = 1'b1;
                end
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    assign accept = (state_q == ST_IDLE) && req_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Access context, wait counter and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            isa_q   <= 1'b0;
            hit_q   <= 1'b0;
            sel_q   <= '0;
            cnt_q   <= '0;
            rsp_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
                isa_q   <= cfg_isa;
                hit_q   <= dec_hit;
                sel_q   <= dec_sel;
                cnt_q   <= wait_total;
            end else if (state_q == ST_WAIT) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
            rsp_q <= end_acc;
            if (end_acc && !write_q) begin
                rdata_q <= hit_q ? bus_din : '1;
            end
        end
    end

    // Outputs
    always_comb begin
        active    = (state_q != ST_IDLE);
        strobe_ph = (state_q == ST_STROBE) || (state_q == ST_WAIT);
        req_ready = (state_q == ST_IDLE);
        rsp_valid = rsp_q;
        rsp_rdata = rdata_q;
        bus_addr  = addr_q;
        bus_dout  = wdata_q;
        bus_oe    = write_q && active;
        bus_cs_n  = ~(sel_q & {NCS{active}});
        bus_wr_n  = !(write_q && strobe_ph);
        bus_rd_n  = !(!write_q && strobe_ph && (!isa_q || late_q));
    end
endmodule

// File: rtl/xbus_wait_ctrl_chk.sv
module xbus_wait_ctrl_chk #(
    parameter int NCS    = 4,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [NCS-1:0]    bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_oe,
    input logic [ADDR_W-1:0] bus_addr
);
    // R2
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));

    // R3
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (req_ready && (&bus_cs_n)));

    // R8
    oe_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_oe && !bus_rd_n));

    // R5
    wr_with_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> bus_oe);

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(bus_addr));
endmodule

bind xbus_wait_ctrl xbus_wait_ctrl_chk #(.NCS(NCS), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_oe(bus_oe), .bus_addr(bus_addr)
);

// File: tb/xbus_wait_ctrl_tb_top.sv
`timescale 1ns/1ps
module xbus_wait_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0, bus_din = '0;
    logic        req_ready, rsp_valid, bus_oe, bus_rd_n, bus_wr_n, cfg_isa = 1'b0;
    logic [15:0] rsp_rdata, bus_dout;
    logic [23:0] bus_addr;
    logic [3:0]  bus_cs_n;
    logic [3:0]  cfg_en      = 4'b0111;
    logic [95:0] cfg_base    = {24'h200000, 24'h100000, 24'h100000, 24'h000000};
    logic [19:0] cfg_size    = {5'd8, 5'd20, 5'd16, 5'd12};
    logic [15:0] cfg_wait_lo = {4'd3, 4'd5, 4'd2, 4'd0};
    logic [7:0]  cfg_wait_hi = {2'd0, 2'd1, 2'd0, 2'd0};
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    xbus_wait_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_isa(cfg_isa),
        .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .bus_din(bus_din), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Called mid-cycle (after the falling edge) while the block is idle.
    task automatic access(input logic [23:0] a, input logic wr, input logic [15:0] wd,
                          input logic [15:0] din, input int cs_idx, input int n,
                          input logic isa, input string tag);
        logic [3:0] exp_cs;
        cfg_isa   = isa;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        bus_din   = din;
        @(posedge clk);
        #5;
        req_valid = 1'b0;
        req_addr  = ~a;
        req_wdata = ~wd;
        for (int k = 0; k <= n + 2; k++) begin
            if (k > 0) begin
                @(posedge clk);
                #5;
            end
            exp_cs = (k <= n + 1 && cs_idx >= 0) ? ~(4'b1 << cs_idx) : 4'hF;
            chk(cs_idx >= 0 ? "R2" : "R7", "cs_n", 32'(bus_cs_n), 32'(exp_cs));
            chk(tag, "req_ready", 32'(req_ready), 32'(k == n + 2));
            chk(tag, "rsp_valid", 32'(rsp_valid), 32'(k == n + 2));
            chk("R8", "oe", 32'(bus_oe), 32'(wr && k <= n + 1));
            chk(isa ? "R5" : tag, "wr_n", 32'(bus_wr_n), 32'(!(wr && k >= 1 && k <= n + 1)));
            chk(isa ? "R4" : tag, "rd_n early", 32'(bus_rd_n),
                32'(!(!wr && k >= 1 && k <= n + 1 && !(isa && k == 1))));
            chk("R11", "addr", 32'(bus_addr), 32'(a));
            if (wr && k <= n + 1) chk("R8", "dout", 32'(bus_dout), 32'(wd));
            #10;
            chk(isa ? "R4" : tag, "rd_n late", 32'(bus_rd_n), 32'(!(!wr && k >= 1 && k <= n + 1)));
            if (k == n + 2 && !wr) begin
                chk(cs_idx >= 0 ? "R9" : "R7", "rdata", 32'(rsp_rdata),
                    32'(cs_idx >= 0 ? din : 16'hFFFF));
            end
        end
    endtask

    task automatic gap();
        @(negedge clk);
        #5;
    endtask

    initial begin
        #3_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #35;
        // R1: reset state
        chk("R1", "ready", 32'(req_ready), 32'd1);
        chk("R1", "cs_n", 32'(bus_cs_n), 32'hF);
        chk("R1", "rd_n", 32'(bus_rd_n), 32'd1);
        chk("R1", "wr_n", 32'(bus_wr_n), 32'd1);
        chk("R1", "oe", 32'(bus_oe), 32'd0);
        chk("R1", "rsp", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        gap();

        // Sweep region 0 fields, ISA mode and direction (R3, R4, R5, R6).
        for (int lo = 0; lo < 16; lo++) begin
            for (int hi = 0; hi < 4; hi++) begin
                for (int isa = 0; isa < 2; isa++) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        int raw, n;
                        string tag;
                        cfg_wait_lo[3:0] = 4'(lo);
                        cfg_wait_hi[1:0] = 2'(hi);
                        raw = lo + 8 * hi + ((isa == 1 && wr == 0) ? 1 : 0);
                        n = (raw > 31) ? 31 : raw;
                        tag = (raw > 31) ? "R6" : ((isa == 1) ? ((wr == 1) ? "R5" : "R4") : "R3");
                        access(24'h000100 + 24'(lo * 16 + hi * 4 + isa * 2 + wr), wr[0],
                               16'(16'h5A00 + lo * 8 + hi), 16'(16'hC300 + lo * 4 + hi),
                               0, n, isa[0], tag);
                        gap();
                    end
                end
            end
        end

        // Overlap: region 1 wins over region 2 (R2)
        access(24'h10ABCD, 1'b0, 16'h0, 16'h1234, 1, 2, 1'b0, "R2");
        gap();
        access(24'h10ABCE, 1'b0, 16'h0, 16'h4321, 1, 3, 1'b1, "R4");
        gap();
        // Region 2 only: 5 + 8 = 13
        access(24'h1F0000, 1'b1, 16'hBEEF, 16'h0, 2, 13, 1'b1, "R5");
        gap();
        access(24'h1F0002, 1'b0, 16'h0, 16'h7E57, 2, 14, 1'b1, "R4");
        gap();
        // Disabled region and unmapped space (R7)
        access(24'h200010, 1'b0, 16'h0, 16'h9999, -1, 0, 1'b1, "R7");
        gap();
        access(24'h800000, 1'b1, 16'hA5A5, 16'h0, -1, 0, 1'b0, "R7");
        gap();

        // Back-to-back: next request issued in the response clock (R10)
        cfg_wait_lo[3:0] = 4'd1;
        cfg_wait_hi[1:0] = 2'd0;
        access(24'h000020, 1'b0, 16'h0, 16'h2468, 0, 1, 1'b0, "R3");
        chk("R10", "ready with rsp", 32'(req_ready && rsp_valid), 32'd1);
        chk("R10", "cs idle", 32'(bus_cs_n), 32'hF);
        access(24'h10FFFE, 1'b1, 16'h1357, 16'h0, 1, 2, 1'b0, "R10");
        access(24'h000040, 1'b0, 16'h0, 16'hFACE, 0, 2, 1'b1, "R10");
        gap();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule